// File: doc/BRIEF.md
# SCSI Controller Configuration Register and Bit-Driven Logic

This block holds the host-writable 8-bit configuration word of a SCSI bus controller and the small pieces of logic its bits steer directly. It generates parity for bytes leaving the device and checks parity on bytes arriving from the bus. It decides whether a SCSI bus reset interrupts the host. It adds an optional extra clock of data setup before the transfer strobe (REQ or ACK) is raised. It also has a self-test mode that, once entered, can only be left through a reset.

The host reaches the block through a small register port with address, write data, read and write strobes. Read data is registered. A hard reset and a soft reset both return the mode bits to their idle values. The 3-bit bus ID survives both resets, so an ID programmed once stays valid across soft restarts. Phase sequencing, arbitration, FIFO and DMA live elsewhere. They use the `my_id`, `tx_*` and `atn_out` signals of this block.

Top module: `scsi_cfg_ctrl`

## Requirements
- R1: A hard reset (`rst`) or a soft reset (`soft_rst`), both synchronous, clears configuration bits 7..3, the test register, the parity-error flag, ATN and the pending bus-reset interrupt. Configuration bits 2..0 (the bus ID) keep their value.
- R2: Offset 0x8 holds the configuration word, laid out as bit 7 = extended setup, bit 6 = bus-reset interrupt mask, bit 5 = parity force, bit 4 = parity check enable, bit 3 = self test, bits 2..0 = bus ID. A read returns all eight bits as last written, and `my_id` presents bits 2..0. Read data appears on `host_rdata` in the cycle after the read strobe.
- R3: A byte accepted by `tx_load` appears on `tx_bus_data` one cycle later. `tx_bus_par` is odd parity over the byte, or bit 7 of the byte when parity force is set.
- R4: `tx_strobe` is a one-cycle pulse. It rises two cycles after `tx_load` is sampled when extended setup is clear, and three cycles after when it is set. `tx_bus_data` holds steady until the strobe.
- R5: A rising edge on `bus_rst_in` pulses `bus_release` for one cycle. It also raises `host_irq` when the interrupt mask bit is clear, and leaves `host_irq` low when the mask bit is set.
- R6: When parity check enable is set, a byte with `rx_valid` and `info_phase` high whose nine bits have an even count of ones sets `par_err` (status bit 0). This never raises `host_irq`. When checking is disabled, or outside the information phase, bad parity is ignored.
- R7: A parity error detected while `initiator` is high also asserts `atn_out`. Without `initiator`, `atn_out` stays low.
- R8: A read of offset 0x4 returns status {6'b0, bus-reset interrupt, parity error} and clears the parity-error flag, ATN and the interrupt in the same cycle. A new event in that cycle wins over the clear.
- R9: Once the self-test bit is set, a host write of 0 to it leaves it set.
- R10: Offset 0xA is a test register. It reads back as written while self test is set. Otherwise it reads 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| host_irq | output | 1 | Bus-reset interrupt to host |
| bus_rst_in | input | 1 | SCSI bus reset level |
| bus_release | output | 1 | One-cycle request to leave the bus and go idle |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_par | input | 1 | Incoming parity bit |
| info_phase | input | 1 | Bus is in an information transfer phase |
| initiator | input | 1 | Device acts as initiator |
| atn_out | output | 1 | ATN request after a parity error |
| par_err | output | 1 | Sticky parity-error flag |
| tx_load | input | 1 | Accept a byte for sending |
| tx_data | input | 8 | Byte to send |
| tx_bus_data | output | 8 | Byte driven to the bus |
| tx_bus_par | output | 1 | Parity driven to the bus |
| tx_strobe | output | 1 | REQ/ACK strobe pulse |
| my_id | output | 3 | Bus ID |

## Verification
On every cycle the assertions check the following: the stickiness of self test, the absence of a strobe inside the setup window, the one-cycle width of the strobe, and that data holds steady while the setup counter runs. They also check that the parity flag and the interrupt can only rise when their enabling bit permits it, and that ATN only rises for an initiator. The bench scenarios show the rest. These are the actual parity values in both parity modes, the exact strobe latency for each setup mode, the survival of the bus ID across both resets, the clear-on-read of status, and the gated access to the test register.

// File: rtl/scsi_cfg_pkg.sv
package scsi_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int ID_W   = 3;
  localparam int STAT_W = 2;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_TEST   = 4'hA;

  localparam int STAT_PERR   = 0;
  localparam int STAT_RSTIRQ = 1;

  typedef struct packed {
    logic            ext_setup;
    logic            rst_irq_mask;
    logic            par_force;
    logic            par_check;
    logic            self_test;
    logic [ID_W-1:0] bus_id;
  } cfg_word_t;
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import scsi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_any,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [STAT_W-1:0] status_in,
  output logic [DATA_W-1:0] host_rdata,
  output cfg_word_t         cfg,
  output logic              status_rd
);
  logic [DATA_W-1:0] test_q;
  logic [ID_W-1:0]   id_q;
  logic              ext_q, mask_q, force_q, check_q, st_q;
  logic              wr_cfg, wr_test;
  logic [DATA_W-1:0] rd_mux;

  assign wr_cfg    = host_wr && (host_addr == OFS_CTRL);
  assign wr_test   = host_wr && (host_addr == OFS_TEST) && st_q;
  assign status_rd = host_rd && (host_addr == OFS_STATUS);

  // Mode bits: cleared by either reset.
  always_ff @(posedge clk) begin
    if (rst_any) begin
      ext_q   <= 1'b0;
      mask_q  <= 1'b0;
      force_q <= 1'b0;
      check_q <= 1'b0;
      st_q    <= 1'b0;
    end else if (wr_cfg) begin
      ext_q   <= host_wdata[7];
      mask_q  <= host_wdata[6];
      force_q <= host_wdata[5];
      check_q <= host_wdata[4];
      st_q    <= st_q | host_wdata[3];
    end
  end

  // Bus ID: untouched by any reset.
  always_ff @(posedge clk) begin
    if (wr_cfg) id_q <= host_wdata[ID_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst_any)      test_q <= '0;
    else if (wr_test) test_q <= host_wdata;
  end

  assign cfg = '{ext_setup: ext_q, rst_irq_mask: mask_q, par_force: force_q,
                 par_check: check_q, self_test: st_q, bus_id: id_q};

  always_comb begin
    rd_mux = '0;
    unique case (host_addr)
      OFS_CTRL:   rd_mux = cfg;
      OFS_STATUS: rd_mux = {{(DATA_W-STAT_W){1'b0}}, status_in};
      OFS_TEST:   rd_mux = st_q ? test_q : '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any)      host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (rst_any)
    st_q |=> st_q); // R9
  AST_TEST_LOCKED: assert property (@(posedge clk) disable iff (rst_any)
    !st_q && !wr_cfg |=> $stable(test_q)); // R10
endmodule

// File: rtl/tx_path.sv
module tx_path
  import scsi_cfg_pkg::*;
#(
  parameter int BASE_SETUP = 1
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              ext_setup,
  input  logic              par_force,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] tx_bus_data,
  output logic              tx_bus_par,
  output logic              tx_strobe
);
  localparam int CNT_W = $clog2(BASE_SETUP + 2);
  localparam logic [CNT_W-1:0] SETUP_N = CNT_W'(BASE_SETUP);
  localparam logic [CNT_W-1:0] SETUP_X = CNT_W'(BASE_SETUP + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy, accept, par_odd;

  assign busy    = (cnt_q != '0) || tx_strobe;
  assign accept  = tx_load && !busy;
  assign par_odd = ~(^tx_data);

  always_ff @(posedge clk) begin
    if (rst_any) begin
      tx_bus_data <= '0;
      tx_bus_par  <= 1'b1;
    end else if (accept) begin
      tx_bus_data <= tx_data;
      tx_bus_par  <= par_force ? tx_data[DATA_W-1] : par_odd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      cnt_q     <= '0;
      tx_strobe <= 1'b0;
    end else if (accept) begin
      cnt_q     <= ext_setup ? SETUP_X : SETUP_N;
      tx_strobe <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q     <= cnt_q - 1'b1;
      tx_strobe <= (cnt_q == CNT_W'(1));
    end else begin
      tx_strobe <= 1'b0;
    end
  end

  AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (rst_any)
    accept |=> !tx_strobe); // R4
  AST_EXT_SETUP_GAP: assert property (@(posedge clk) disable iff (rst_any)
    accept && ext_setup |=> ##1 !tx_strobe); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst_any)
    tx_strobe |=> !tx_strobe); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst_any)
    (cnt_q != '0) |=> $stable(tx_bus_data)); // R4
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk
  import scsi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_any,
  input  logic              par_check,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  input  logic              info_phase,
  input  logic              initiator,
  input  logic              clr,
  output logic              par_err,
  output logic              atn_out
);
  logic bad, hit;

  assign bad = ~(^{rx_data, rx_par});
  assign hit = par_check && rx_valid && info_phase && bad;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      par_err <= 1'b0;
      atn_out <= 1'b0;
    end else begin
      if (hit)      par_err <= 1'b1;
      else if (clr) par_err <= 1'b0;
      if (hit && initiator) atn_out <= 1'b1;
      else if (clr)         atn_out <= 1'b0;
    end
  end

  AST_PERR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (rst_any)
    !par_err && !(par_check && rx_valid && info_phase) |=> !par_err); // R6
  AST_ATN_INITIATOR: assert property (@(posedge clk) disable iff (rst_any)
    !atn_out && !initiator |=> !atn_out); // R7
endmodule

// File: rtl/bus_rst_unit.sv
module bus_rst_unit (
  input  logic clk,
  input  logic rst_any,
  input  logic rst_irq_mask,
  input  logic bus_rst_in,
  input  logic clr,
  output logic host_irq,
  output logic bus_release
);
  logic prev_q, rise;

  assign rise = bus_rst_in && !prev_q;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      prev_q      <= 1'b0;
      host_irq    <= 1'b0;
      bus_release <= 1'b0;
    end else begin
      prev_q      <= bus_rst_in;
      bus_release <= rise;
      if (rise && !rst_irq_mask) host_irq <= 1'b1;
      else if (clr)              host_irq <= 1'b0;
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst_any)
    !host_irq && rst_irq_mask |=> !host_irq); // R5
  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (rst_any)
    bus_release |=> !bus_release); // R5
endmodule

// File: rtl/scsi_cfg_ctrl.sv
module scsi_cfg_ctrl
  import scsi_cfg_pkg::*;
#(
  parameter int BASE_SETUP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              bus_rst_in,
  output logic              bus_release,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  input  logic              info_phase,
  input  logic              initiator,
  output logic              atn_out,
  output logic              par_err,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] tx_bus_data,
  output logic              tx_bus_par,
  output logic              tx_strobe,
  output logic [ID_W-1:0]   my_id
);
  logic              rst_any, status_rd;
  cfg_word_t         cfg;
  logic [STAT_W-1:0] status;

  assign rst_any = rst | soft_rst;
  assign my_id   = cfg.bus_id;

  always_comb begin
    status              = '0;
    status[STAT_PERR]   = par_err;
    status[STAT_RSTIRQ] = host_irq;
  end

  cfg_regs u_regs (
    .clk(clk), .rst_any(rst_any), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .status_in(status),
    .host_rdata(host_rdata), .cfg(cfg), .status_rd(status_rd)
  );

  tx_path #(.BASE_SETUP(BASE_SETUP)) u_tx (
    .clk(clk), .rst_any(rst_any), .ext_setup(cfg.ext_setup), .par_force(cfg.par_force),
    .tx_load(tx_load), .tx_data(tx_data), .tx_bus_data(tx_bus_data),
    .tx_bus_par(tx_bus_par), .tx_strobe(tx_strobe)
  );

  rx_parity_chk u_rx (
    .clk(clk), .rst_any(rst_any), .par_check(cfg.par_check), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_par(rx_par), .info_phase(info_phase),
    .initiator(initiator), .clr(status_rd), .par_err(par_err), .atn_out(atn_out)
  );

  bus_rst_unit u_brst (
    .clk(clk), .rst_any(rst_any), .rst_irq_mask(cfg.rst_irq_mask),
    .bus_rst_in(bus_rst_in), .clr(status_rd), .host_irq(host_irq),
    .bus_release(bus_release)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst_any |=> !par_err && !atn_out && !host_irq && !tx_strobe); // R1
  AST_PERR_NO_IRQ: assert property (@(posedge clk) disable iff (rst_any)
    !host_irq && !(bus_rst_in && !cfg.rst_irq_mask) |=> !host_irq); // R6
endmodule

// File: tb/test_scsi_cfg_ctrl.sv
module test_scsi_cfg_ctrl;
  logic       clk = 0, rst = 1, soft_rst = 0;
  logic [3:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic       host_wr = 0, host_rd = 0, host_irq;
  logic       bus_rst_in = 0, bus_release;
  logic       rx_valid = 0, rx_par = 0, info_phase = 0, initiator = 0;
  logic [7:0] rx_data = 0;
  logic       atn_out, par_err;
  logic       tx_load = 0;
  logic [7:0] tx_data = 0, tx_bus_data;
  logic       tx_bus_par, tx_strobe;
  logic [2:0] my_id;

  int n_chk = 0, n_fail = 0, cyc = 0;
  typedef struct { logic [7:0] d; logic p; int t; } tx_exp_t;
  tx_exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scsi_cfg_ctrl i_scsi_cfg_ctrl (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  // Driver: pushes expected byte, parity and strobe time.
  task automatic send(logic [7:0] d, logic force_m, logic ext);
    tx_exp_t e;
    @(negedge clk);
    e.d = d; e.p = force_m ? d[7] : ~(^d); e.t = cyc + (ext ? 3 : 2);
    q.push_back(e);
    tx_data = d; tx_load = 1;
    @(negedge clk); tx_load = 0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops on each strobe.
  always @(negedge clk) begin
    if (tx_strobe) begin
      if (q.size() == 0) check("R4 unexpected strobe", 8'h1, 8'h0);
      else begin
        tx_exp_t e;
        e = q.pop_front();
        check("R3 data", tx_bus_data, e.d);
        check("R3 parity", {7'b0, tx_bus_par}, {7'b0, e.p});
        check("R4 strobe cycle", 8'(cyc - e.t), 8'h0);
      end
    end
  end

  task automatic rx_byte(logic [7:0] d, logic p, logic info);
    @(negedge clk); rx_data = d; rx_par = p; rx_valid = 1; info_phase = info;
    @(negedge clk); rx_valid = 0; info_phase = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk); rst = 0;
    check("R1 reset irq", {7'b0, host_irq}, 8'h0);
    check("R1 reset perr", {7'b0, par_err}, 8'h0);
    rd(4'h8, v); check("R1 reset mode bits", v & 8'hF8, 8'h0);

    wr(4'h8, 8'h05); rd(4'h8, v); check("R2 readback", v, 8'h05);
    check("R2 my_id", {5'b0, my_id}, 8'h05);
    wr(4'h8, 8'hE2); rd(4'h8, v); check("R2 readback all", v, 8'hE2);

    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    rd(4'h8, v); check("R1 soft reset keeps ID", v, 8'h02);

    send(8'h00, 0, 0); send(8'h01, 0, 0); send(8'hFF, 0, 0);
    wr(4'h8, 8'h82); send(8'h3C, 0, 1);
    wr(4'h8, 8'h22); send(8'h80, 1, 0); send(8'h03, 1, 0);
    check("R4 queue drained", 8'(q.size()), 8'h0);

    wr(4'h8, 8'h12);
    rx_byte(8'h01, 1'b0, 1); check("R6 good byte", {7'b0, par_err}, 8'h0);
    rx_byte(8'h01, 1'b1, 1); check("R6 bad byte", {7'b0, par_err}, 8'h1);
    check("R7 no atn as target", {7'b0, atn_out}, 8'h0);
    check("R6 no irq", {7'b0, host_irq}, 8'h0);
    rd(4'h4, v); check("R8 status perr", v, 8'h01);
    check("R8 cleared", {7'b0, par_err}, 8'h0);
    initiator = 1;
    rx_byte(8'h00, 1'b0, 1); check("R7 atn initiator", {7'b0, atn_out}, 8'h1);
    rd(4'h4, v); check("R8 atn cleared", {7'b0, atn_out}, 8'h0);
    initiator = 0;
    rx_byte(8'h00, 1'b0, 0); check("R6 outside info phase", {7'b0, par_err}, 8'h0);
    wr(4'h8, 8'h02);
    rx_byte(8'h00, 1'b0, 1); check("R6 check disabled", {7'b0, par_err}, 8'h0);

    @(negedge clk); bus_rst_in = 1;
    @(negedge clk); check("R5 release", {7'b0, bus_release}, 8'h1);
    check("R5 irq unmasked", {7'b0, host_irq}, 8'h1);
    @(negedge clk); bus_rst_in = 0;
    rd(4'h4, v); check("R8 status irq", v, 8'h02);
    check("R8 irq cleared", {7'b0, host_irq}, 8'h0);
    wr(4'h8, 8'h42);
    @(negedge clk); bus_rst_in = 1;
    @(negedge clk); check("R5 release masked", {7'b0, bus_release}, 8'h1);
    check("R5 irq masked", {7'b0, host_irq}, 8'h0);
    @(negedge clk); bus_rst_in = 0;
    @(negedge clk); check("R5 irq stays masked", {7'b0, host_irq}, 8'h0);

    wr(4'hA, 8'h5A); rd(4'hA, v); check("R10 locked read", v, 8'h00);
    wr(4'h8, 8'h0A); rd(4'hA, v); check("R10 write ignored while locked", v, 8'h00);
    wr(4'hA, 8'h5A); rd(4'hA, v); check("R10 open", v, 8'h5A);
    wr(4'h8, 8'h02); rd(4'h8, v); check("R9 sticky", v, 8'h0A);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(4'h8, v); check("R1 hard reset keeps ID", v, 8'h02);
    rd(4'hA, v); check("R1 test reg cleared", v, 8'h00);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule